// File: doc/BRIEF.md
# Configurable Single-Cycle ALU Datapath

This block is one processing element of a reconfigurable array. It takes four 16-bit operands, and each operand is captured in its own register. Every result is then formed by combinational logic within the same cycle. That logic is a fractional multiplier followed by two add/subtract stages in a chain. A control word, applied fresh on every cycle, sets which registers load, which operands feed the multiplier and each adder, whether each adder adds or subtracts, and what value leaves on the neighbour link.

The two result outputs and the neighbour output have no registers. A neighbour value from an adjacent element can enter either adder in the same cycle it arrives. A short dataflow, for example a product that feeds a sum that feeds a difference, therefore completes in the cycle after its operands are loaded. Elements can be chained through the neighbour ports.

Top module: `fused_alu`

## Requirements
- R1: Asserting rst_ni low clears all four operand registers at once, without waiting for a clock. With an all-zero control word and a zero neighbour input, res0_o, res1_o and nbr_o all read 0.
- R2: The control word occupies ctrl_i[18:0]. Operand register k (k = 0..3, taken from opnd_i[16k+15:16k]) loads on a rising clock edge only when ctrl_i[15+k] is set. Otherwise it holds its value.
- R3: The multiplier operands are picked by ctrl_i[14:13] and ctrl_i[12:11], where value k selects register k. The product is the signed 32-bit product shifted right arithmetically by 15, which rounds toward minus infinity.
- R4: A Q15 product that exceeds 0x7FFF saturates to 0x7FFF. The only such case is 0x8000 times 0x8000.
- R5: Stage 0 forms res0_o. Its X operand is chosen by ctrl_i[10:9] (0 = reg0, 1 = reg1, 2 = product, 3 = nbr_i). Its Y operand is chosen by ctrl_i[8:7] (0 = reg2, 1 = reg3, 2 = product, 3 = nbr_i). ctrl_i[6] = 1 gives X minus Y, and 0 gives X plus Y.
- R6: Stage 1 forms res1_o. Its X operand is chosen by ctrl_i[5:4] (0 = stage 0 result, 1 = reg0, 2 = product, 3 = nbr_i). Its Y operand is chosen by ctrl_i[3:2] (0 = reg2, 1 = reg3, 2 = product, 3 = nbr_i). ctrl_i[1] = 1 selects subtraction.
- R7: A change on nbr_i reaches the results combinationally, with no clock edge in between.
- R8: nbr_o carries the product when ctrl_i[0] = 1 and the stage 1 result when ctrl_i[0] = 0.
- R9: A change on ctrl_i reconfigures the outputs in the same cycle, with no clock edge in between.
- R10: Both adders wrap modulo 2^16 and do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 64 | Four operands; operand k at bits [16k+15:16k] |
| nbr_i | input | 16 | Value from the adjacent element |
| ctrl_i | input | 19 | Per-cycle control word |
| res0_o | output | 16 | Stage 0 result, unregistered |
| res1_o | output | 16 | Stage 1 result, unregistered |
| nbr_o | output | 16 | Value to the adjacent element, unregistered |

## Verification
The vector table drives the datapath with several kinds of operand pairs. Q15 pairs of equal sign separate the 15-bit shift from a plain truncation. A pair of -1 and +1 tells floor rounding apart from rounding toward zero. Full-scale negative pairs exercise saturation and the largest negative product. Sums that cross the 16-bit range show that the adders wrap rather than clamp. Each row steers the selects to different sources so that every mux leg is covered. Directed steps then load one register while offering new data to the other three, which separates enable gating from free loading. Other steps change nbr_i or a single subtract bit with no clock edge, which separates combinational paths from registered ones.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
  localparam int unsigned N_OPND = 4;
  localparam int unsigned SEL_W  = $clog2(N_OPND);

  typedef struct packed {
    logic [N_OPND-1:0] ld_en;
    logic [SEL_W-1:0]  mul_a_sel;
    logic [SEL_W-1:0]  mul_b_sel;
    logic [SEL_W-1:0]  s0_x_sel;
    logic [SEL_W-1:0]  s0_y_sel;
    logic              s0_sub;
    logic [SEL_W-1:0]  s1_x_sel;
    logic [SEL_W-1:0]  s1_y_sel;
    logic              s1_sub;
    logic              nbr_sel;
  } alu_ctrl_t;

  localparam int unsigned CTRL_W = $bits(alu_ctrl_t);
endpackage

// File: rtl/fused_alu_opnd_regs.sv
module fused_alu_opnd_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_REG  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_REG-1:0]             ld_en_i,
  input  logic [N_REG*DATA_W-1:0]      d_i,
  output logic [N_REG-1:0][DATA_W-1:0] q_o
);
  for (genvar k = 0; k < N_REG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[k] <= '0;
      else if (ld_en_i[k]) q_o[k] <= d_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/fused_alu_q15_mul.sv
module fused_alu_q15_mul #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] p_o
);
  localparam int unsigned PW   = 2 * DATA_W;
  localparam int unsigned FRAC = DATA_W - 1;
  localparam logic signed [PW-1:0] MAX_V =
    $signed({{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PW-1:0] MIN_V =
    $signed({{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] shifted;

  always_comb begin
    full    = PW'($signed(a_i)) * PW'($signed(b_i));
    shifted = full >>> FRAC;
    if (shifted > MAX_V)      p_o = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) p_o = MIN_V[DATA_W-1:0];
    else                      p_o = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/fused_alu_stage.sv
module fused_alu_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_SRC  = 4,
  localparam int unsigned SW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0][DATA_W-1:0] x_src_i,
  input  logic [N_SRC-1:0][DATA_W-1:0] y_src_i,
  input  logic [SW-1:0]                x_sel_i,
  input  logic [SW-1:0]                y_sel_i,
  input  logic                         sub_i,
  output logic [DATA_W-1:0]            sum_o
);
  logic [DATA_W-1:0] x_op, y_op;

  always_comb begin
    x_op  = x_src_i[x_sel_i];
    y_op  = y_src_i[y_sel_i];
    // modular result: no saturation in the adders
    sum_o = sub_i ? (x_op - y_op) : (x_op + y_op);
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fused_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_OPND*DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0]        nbr_i,
  input  logic [CTRL_W-1:0]        ctrl_i,
  output logic [DATA_W-1:0]        res0_o,
  output logic [DATA_W-1:0]        res1_o,
  output logic [DATA_W-1:0]        nbr_o
);
  alu_ctrl_t ctrl;
  logic [N_OPND-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0] mul_a, mul_b, prod;
  logic [N_OPND-1:0][DATA_W-1:0] s0_x_src, s0_y_src, s1_x_src, s1_y_src;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  fused_alu_opnd_regs #(.DATA_W(DATA_W), .N_REG(N_OPND)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_en_i (ctrl.ld_en),
    .d_i     (opnd_i),
    .q_o     (regs_q)
  );

  assign mul_a = regs_q[ctrl.mul_a_sel];
  assign mul_b = regs_q[ctrl.mul_b_sel];

  fused_alu_q15_mul #(.DATA_W(DATA_W)) u_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (prod)
  );

  // source order per select code: see brief R5/R6
  assign s0_x_src = {nbr_i, prod, regs_q[1], regs_q[0]};
  assign s0_y_src = {nbr_i, prod, regs_q[3], regs_q[2]};
  assign s1_x_src = {nbr_i, prod, regs_q[0], res0_o};
  assign s1_y_src = {nbr_i, prod, regs_q[3], regs_q[2]};

  fused_alu_stage #(.DATA_W(DATA_W), .N_SRC(N_OPND)) u_stage0 (
    .x_src_i (s0_x_src),
    .y_src_i (s0_y_src),
    .x_sel_i (ctrl.s0_x_sel),
    .y_sel_i (ctrl.s0_y_sel),
    .sub_i   (ctrl.s0_sub),
    .sum_o   (res0_o)
  );

  fused_alu_stage #(.DATA_W(DATA_W), .N_SRC(N_OPND)) u_stage1 (
    .x_src_i (s1_x_src),
    .y_src_i (s1_y_src),
    .x_sel_i (ctrl.s1_x_sel),
    .y_sel_i (ctrl.s1_y_sel),
    .sub_i   (ctrl.s1_sub),
    .sum_o   (res1_o)
  );

  assign nbr_o = ctrl.nbr_sel ? prod : res1_o;
endmodule

// File: rtl/fused_alu_chk.sv
module fused_alu_chk
  import fused_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_OPND*DATA_W-1:0]      opnd_i,
  input logic [CTRL_W-1:0]             ctrl_i,
  input logic [N_OPND-1:0][DATA_W-1:0] regs_q,
  input logic [DATA_W-1:0]             mul_a,
  input logic [DATA_W-1:0]             mul_b,
  input logic [DATA_W-1:0]             prod,
  input logic [DATA_W-1:0]             res1_o,
  input logic [DATA_W-1:0]             nbr_o
);
  alu_ctrl_t c;
  assign c = alu_ctrl_t'(ctrl_i);

  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};

  for (genvar k = 0; k < N_OPND; k++) begin : g_chk
    assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c.ld_en[k] |=> regs_q[k] == $past(opnd_i[k*DATA_W +: DATA_W]));
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !c.ld_en[k] |=> $stable(regs_q[k]));
  end

  assert_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_a == NEG_FS && mul_b == NEG_FS) |-> prod == POS_FS);

  assert_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_a[DATA_W-1] != mul_b[DATA_W-1] && mul_a != '0 && mul_b != '0)
      |-> prod[DATA_W-1]);

  assert_link_prod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.nbr_sel |-> nbr_o == prod);

  assert_link_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c.nbr_sel |-> nbr_o == res1_o);
endmodule

bind fused_alu fused_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .opnd_i (opnd_i),
  .ctrl_i (ctrl_i),
  .regs_q (regs_q),
  .mul_a  (mul_a),
  .mul_b  (mul_b),
  .prod   (prod),
  .res1_o (res1_o),
  .nbr_o  (nbr_o)
);

// File: tb/fused_alu_tb.sv
module fused_alu_tb;
  localparam int VW = 19 + 64 + 16 + 48;
  localparam int NV = 5;

  // {ctrl, opnd{D,C,B,A}, nbr, exp res0, exp res1, exp nbr_o}
  localparam logic [VW-1:0] VEC [NV] = '{
    // R3 R5 R6: 0.5*0.5, prod+C, sum0-D
    {4'hF,2'd0,2'd1,2'd2,2'd0,1'b0,2'd0,2'd1,1'b1,1'b0,
     16'h0003,16'h0010,16'h4000,16'h4000, 16'h0100, 16'h2010,16'h200D,16'h200D},
    // R4 R8 R10: saturation, wrap, product on link
    {4'hF,2'd0,2'd1,2'd2,2'd2,1'b0,2'd2,2'd3,1'b0,1'b1,
     16'h0000,16'h0000,16'h8000,16'h8000, 16'h0001, 16'hFFFE,16'h8000,16'h7FFF},
    // R3 floor: -1*1 -> -1 ; R5 nbr-D ; R6 prod-C
    {4'hF,2'd0,2'd1,2'd3,2'd1,1'b1,2'd2,2'd0,1'b1,1'b0,
     16'h0034,16'h0005,16'h0001,16'hFFFF, 16'h1234, 16'h1200,16'hFFFA,16'hFFFA},
    // R3 largest negative ; R10 wraps
    {4'hF,2'd0,2'd1,2'd0,2'd0,1'b1,2'd1,2'd2,1'b0,1'b1,
     16'h0000,16'h0001,16'h7FFF,16'h8000, 16'h0000, 16'h7FFF,16'h0001,16'h8001},
    // R3 C*D selects ; R6 nbr+prod
    {4'hF,2'd2,2'd3,2'd1,2'd2,1'b0,2'd3,2'd2,1'b0,1'b0,
     16'hC000,16'h2000,16'h0002,16'h0007, 16'h0FFE, 16'hF002,16'hFFFE,16'hFFFE}
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] opnd;
  logic [15:0] nbr_in;
  logic [18:0] ctrl;
  logic [15:0] res0, res1, nbr_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fused_alu u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .opnd_i (opnd),
    .nbr_i  (nbr_in),
    .ctrl_i (ctrl),
    .res0_o (res0),
    .res1_o (res1),
    .nbr_o  (nbr_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk(input logic [3:0] ld, input logic [1:0] ma, mb,
                                     x0, y0, input logic s0, input logic [1:0] x1, y1,
                                     input logic s1, ns);
    return {ld, ma, mb, x0, y0, s0, x1, y1, s1, ns};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opnd   = '0;
    nbr_in = '0;
    ctrl   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 res0 after reset", res0, 16'h0000);
    chk("R1 res1 after reset", res1, 16'h0000);
    chk("R1 nbr_o after reset", nbr_out, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ctrl, opnd, nbr_in} = VEC[i][VW-1:48];
      @(negedge clk);
      chk($sformatf("R3/R5 vec%0d res0", i), res0, VEC[i][47:32]);
      chk($sformatf("R6/R10 vec%0d res1", i), res1, VEC[i][31:16]);
      chk($sformatf("R8 vec%0d nbr_o", i), nbr_out, VEC[i][15:0]);
    end

    // R2: only reg0 enabled; regs now A=7 B=2 C=2000 D=C000
    @(negedge clk);
    ctrl = mk(4'b0001, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
    opnd = {16'h0999, 16'h0999, 16'h0999, 16'h0011};
    nbr_in = '0;
    @(negedge clk);
    ctrl = mk(4'b0000, 2'd1, 2'd3, 2'd0, 2'd0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0);
    #1;
    chk("R2 reg0 loaded, reg2 held (res0)", res0, 16'h2011);
    chk("R2 reg1/reg3 held (res1)", res1, 16'hBFFF);
    @(posedge clk);
    @(negedge clk);
    chk("R2 no load with enables clear", res0, 16'h2011);

    // R7: neighbour value without a clock edge
    ctrl = mk(4'b0000, 2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
    nbr_in = 16'h0001;
    #1;
    chk("R7 nbr_i=0001 res0", res0, 16'h2001);
    nbr_in = 16'h0100;
    #1;
    chk("R7 nbr_i=0100 res0", res0, 16'h2100);

    // R9: reconfigure within a cycle
    ctrl = mk(4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0);
    #1;
    chk("R9 subtract res0", res0, 16'hE011);
    ctrl[6] = 1'b0;
    #1;
    chk("R9 add res0", res0, 16'h2011);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    ctrl   = '0;
    nbr_in = '0;
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async res0", res0, 16'h0000);
    chk("R1 async res1", res1, 16'h0000);
    chk("R1 async nbr_o", nbr_out, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule